// File: doc/BRIEF.md
# Eight-Bit Compare-Match Timer Channel

This block is a single timer channel built around an 8-bit up-counter that advances by one in every cycle its count-enable input is high. Two compare registers, A and B, are checked against the counter. Equality with either one sets a sticky status flag, and so does the counter wrapping from 0xFF to 0x00. A match on compare B also drives a single waveform output pin. A two-bit select field chooses what that pin does on the match: hold its level, go low, go high or invert.

Software reaches the counter, both compare registers and a combined control/status register over a small register bus with a 2-bit address. The status flags are sticky. Software can clear a flag only by first reading it as 1 and then writing 0 to its bit. A plain write of 0 without that read does nothing, and no write can set a flag. The control part of the register also has an enable bit that gates a capture flag, supplied from outside the block, onto an interrupt line.

Top module: `cmt8_channel`

## Requirements
- R1: In every cycle with `cnt_en` high the counter advances by one, wrapping from 0xFF to 0x00. A bus write to address 0 loads `bus_wdata` into the counter and takes precedence over counting in that cycle.
- R2: `bus_rdata` is combinational from `bus_addr`: 0 = counter, 1 = compare A, 2 = compare B, 3 = status. Writes to addresses 1 and 2 load the compare registers. The status layout is: bit 7 = compare-B flag, bit 6 = compare-A flag, bit 5 = overflow flag, bit 4 = capture interrupt enable, bits 3:2 = output select, bits 1:0 read as 0.
- R3: The compare-A flag becomes 1 at the clock edge that ends a cycle in which `cnt_en` is high and the counter equals compare A.
- R4: The compare-B flag becomes 1 at the clock edge that ends a cycle in which `cnt_en` is high and the counter equals compare B.
- R5: The overflow flag becomes 1 at the clock edge where the counter advances from 0xFF to 0x00.
- R6: A read of address 3 (`bus_rd` high) while a flag is 1 arms that flag. The next write to address 3 clears each armed flag whose bit in `bus_wdata` is 0, and that write disarms all flags. A write of 0 to an unarmed flag leaves it set.
- R7: Writing 1 to a flag bit has no effect. Only the matching hardware event can set a flag.
- R8: If a flag's set event and a valid clear come in the same cycle, the flag stays 1.
- R9: On a compare-B match the output pin takes the action given by the select value in force during the match cycle: 00 hold, 01 drive 0, 10 drive 1, 11 invert. The new level shows after the edge that ends the match cycle. Without a match the pin holds its level.
- R10: `cap_irq_o` equals `cap_flag_i` while the enable bit is 1 and is 0 while the enable bit is 0, combinationally.
- R11: After reset the counter, the compare registers, all flags, the output select and `wave_o` are 0, and the capture enable is 1, so status reads 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable, one increment per high cycle |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flags on status reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cap_flag_i | input | 1 | Capture flag from outside the block |
| cap_irq_o | output | 1 | Gated capture interrupt request |
| wave_o | output | 1 | Waveform output driven by compare-B matches |

## Verification
The checker watches every cycle for these rules: a flag always follows its set event, a flag never rises without that event and never falls except on a status write that carries a 0 in its bit, the pin takes the selected action on a compare-B match and holds otherwise, and the registers reach their reset state. The bench's scenarios are the only way to show the read-then-write clear sequence as a whole, since that needs the arming state carried across separate bus accesses. The same holds for a clear that collides with a set, for the pin's response to each select value in turn, and for the capture gating against the enable bit. A randomized run compares every read and both outputs against a model built from the requirements.

// File: rtl/cmt8_pkg.sv
package cmt8_pkg;

    localparam int CNT_W  = 8;
    localparam int ADDR_W = 2;
    localparam int NFLAG  = 3;

    // flag indices inside the flag vector; status bits are {B, A, OVF}
    localparam int FLG_OVF = 0;
    localparam int FLG_CMA = 1;
    localparam int FLG_CMB = 2;

    // status layout
    localparam int ST_FLAG_LSB = 5;
    localparam int ST_IE_BIT   = 4;
    localparam int ST_OS_LSB   = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_CMPA   = 2'd1,
        SEL_CMPB   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OUT_KEEP   = 2'b00,
        OUT_LOW    = 2'b01,
        OUT_HIGH   = 2'b10,
        OUT_TOGGLE = 2'b11
    } out_act_e;

    typedef struct packed {
        logic     irq_en;
        out_act_e osel;
    } ctrl_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [CNT_W-1:0]  wdata;
    } bus_req_t;

    localparam ctrl_t CTRL_RST = '{irq_en: 1'b1, osel: OUT_KEEP};

    function automatic logic apply_act(out_act_e act, logic cur);
        logic r;
        case (act)
            OUT_LOW:    r = 1'b0;
            OUT_HIGH:   r = 1'b1;
            OUT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] pack_status(logic [NFLAG-1:0] flg, ctrl_t c);
        logic [CNT_W-1:0] s;
        s = '0;
        s[ST_FLAG_LSB +: NFLAG] = flg;
        s[ST_IE_BIT]            = c.irq_en;
        s[ST_OS_LSB +: 2]       = c.osel;
        return s;
    endfunction

endpackage

// File: rtl/cmt8_counter.sv
module cmt8_counter
    import cmt8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld_cnt,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_a_q,
    output logic [W-1:0] cmp_b_q,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else begin
            if (ld_cnt)
                cnt_q <= wdata;
            else if (en)
                cnt_q <= cnt_q + 1'b1;
            if (ld_a) cmp_a_q <= wdata;
            if (ld_b) cmp_b_q <= wdata;
        end
    end

    // events are judged on the value the counter holds while it is enabled
    always_comb begin
        hit_a = en && (cnt_q == cmp_a_q);
        hit_b = en && (cnt_q == cmp_b_q);
        wrap  = en && (cnt_q == TOP);
    end

endmodule

// File: rtl/cmt8_flag.sv
module cmt8_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_q
);
    logic armed_q;
    logic clr;

    assign clr = wr_i && armed_q && !wbit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (set_i)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;

            if (rd_i)
                armed_q <= flag_q;
            else if (wr_i)
                armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmt8_wave.sv
module cmt8_wave
    import cmt8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit_i,
    input  out_act_e act_i,
    output logic     wave_q
);
    always_ff @(posedge clk) begin
        if (rst)
            wave_q <= 1'b0;
        else if (hit_i)
            wave_q <= apply_act(act_i, wave_q);
    end

endmodule

// File: rtl/cmt8_channel.sv
module cmt8_channel
    import cmt8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              cap_flag_i,
    output logic              cap_irq_o,
    output logic              wave_o
);
    bus_req_t          req;
    ctrl_t             ctrl_q;
    logic [W-1:0]      cnt_q, cmp_a_q, cmp_b_q;
    logic              hit_a, hit_b, wrap;
    logic [NFLAG-1:0]  evt;
    logic [NFLAG-1:0]  flags_q;
    logic              st_wr, st_rd;
    logic [1:0]        osel_bits;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.sel   = reg_sel_e'(bus_addr);
        req.wdata = bus_wdata;
    end

    assign st_wr = req.wr && (req.sel == SEL_STATUS);
    assign st_rd = req.rd && (req.sel == SEL_STATUS);

    cmt8_counter #(.W(W)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .ld_cnt  (req.wr && req.sel == SEL_COUNT),
        .ld_a    (req.wr && req.sel == SEL_CMPA),
        .ld_b    (req.wr && req.sel == SEL_CMPB),
        .wdata   (req.wdata),
        .cnt_q   (cnt_q),
        .cmp_a_q (cmp_a_q),
        .cmp_b_q (cmp_b_q),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .wrap    (wrap)
    );

    always_comb begin
        evt          = '0;
        evt[FLG_OVF] = wrap;
        evt[FLG_CMA] = hit_a;
        evt[FLG_CMB] = hit_b;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        cmt8_flag flag_i (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt[i]),
            .rd_i   (st_rd),
            .wr_i   (st_wr),
            .wbit_i (req.wdata[ST_FLAG_LSB + i]),
            .flag_q (flags_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (st_wr) begin
            ctrl_q.irq_en <= req.wdata[ST_IE_BIT];
            ctrl_q.osel   <= out_act_e'(req.wdata[ST_OS_LSB +: 2]);
        end
    end

    assign osel_bits = ctrl_q.osel;

    cmt8_wave wave_i (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit_b),
        .act_i  (ctrl_q.osel),
        .wave_q (wave_o)
    );

    always_comb begin
        case (req.sel)
            SEL_COUNT: bus_rdata = cnt_q;
            SEL_CMPA:  bus_rdata = cmp_a_q;
            SEL_CMPB:  bus_rdata = cmp_b_q;
            default:   bus_rdata = pack_status(flags_q, ctrl_q);
        endcase
    end

    assign cap_irq_o = cap_flag_i && ctrl_q.irq_en;

endmodule

// File: rtl/cmt8_channel_chk.sv
module cmt8_channel_chk
    import cmt8_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              wave_o,
    input logic              hit_a,
    input logic              hit_b,
    input logic              wrap,
    input logic [NFLAG-1:0]  flags,
    input logic [1:0]        osel
);
    logic st_wr;
    assign st_wr = bus_wr && (bus_addr == 2'd3);

    // R3
    cma_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit_a |=> flags[FLG_CMA]);

    // R4
    cmb_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit_b |=> flags[FLG_CMB]);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flags[FLG_OVF]);

    // R7
    cmb_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_CMB]) |-> $past(hit_b));

    // R7
    ovf_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_OVF]) |-> $past(wrap));

    // R6
    cma_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[FLG_CMA]) |-> $past(st_wr && !bus_wdata[ST_FLAG_LSB + FLG_CMA]));

    // R9
    wave_low_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_b && osel == 2'b01) |=> !wave_o);

    // R9
    wave_high_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_b && osel == 2'b10) |=> wave_o);

    // R9
    wave_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_b && osel == 2'b11) |=> (wave_o != $past(wave_o)));

    // R9
    wave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hit_b |=> $stable(wave_o));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && osel == 2'b00 && !wave_o));

endmodule

bind cmt8_channel cmt8_channel_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wave_o    (wave_o),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .wrap      (wrap),
    .flags     (flags_q),
    .osel      (osel_bits)
);

// File: tb/cmt8_channel_tb.sv
module cmt8_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cap_flag_i = 1'b0;
    logic       cap_irq_o;
    logic       wave_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_cnt, m_ca, m_cb;
    logic [2:0] m_f, m_arm;
    logic       m_ie, m_wave;
    logic [1:0] m_os;

    logic [7:0] last_rd;
    logic       last_wave, last_irq;

    always #10 clk = ~clk;

    cmt8_channel dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_flag_i(cap_flag_i), .cap_irq_o(cap_irq_o), .wave_o(wave_o)
    );

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return m_ca;
            2'd2:    return m_cb;
            default: return {m_f, m_ie, m_os, 2'b00};
        endcase
    endfunction

    function automatic logic act(logic [1:0] os, logic cur);
        case (os)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic check(logic [7:0] act_v, logic [7:0] exp_v, string tag);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_ca = 0; m_cb = 0; m_f = 0; m_arm = 0;
        m_ie = 1; m_os = 0; m_wave = 0;
    endtask

    // one bus/clock cycle: drive, sample, compare, advance model
    task automatic op(logic [1:0] a, logic w, logic r, logic [7:0] d, logic en, logic cap);
        logic ha, hb, wr_, st_w, st_r;
        logic [2:0] ev;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        cnt_en = en; cap_flag_i = cap;
        #2;
        last_rd = bus_rdata; last_wave = wave_o; last_irq = cap_irq_o;
        check(last_rd, exp_read(a), "R2 read data");
        check({7'd0, last_wave}, {7'd0, m_wave}, "R9 wave level");
        check({7'd0, last_irq}, {7'd0, cap & m_ie}, "R10 irq gate");
        ha = en && m_cnt == m_ca;
        hb = en && m_cnt == m_cb;
        wr_ = en && m_cnt == 8'hFF;
        ev = {hb, ha, wr_};
        st_w = w && a == 2'd3;
        st_r = r && a == 2'd3;
        @(posedge clk);
        for (int i = 0; i < 3; i++) begin
            if (ev[i]) m_f[i] = 1'b1;
            else if (st_w && m_arm[i] && !d[5+i]) m_f[i] = 1'b0;
        end
        // arming uses the flag value before this edge
        for (int i = 0; i < 3; i++) begin
            if (st_r) m_arm[i] = last_rd[5+i] & (a == 2'd3);
            else if (st_w) m_arm[i] = 1'b0;
        end
        if (hb) m_wave = act(m_os, m_wave);
        if (w && a == 2'd0) m_cnt = d;
        else if (en) m_cnt = m_cnt + 8'd1;
        if (w && a == 2'd1) m_ca = d;
        if (w && a == 2'd2) m_cb = d;
        if (st_w) begin m_ie = d[4]; m_os = d[3:2]; end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R11 reset state
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h10, "R11 status reset");
        check({7'd0, last_wave}, 8'h00, "R11 wave reset");
        op(2'd0, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h00, "R11 counter reset");

        // R1 counting and load priority
        op(2'd0, 1, 0, 8'h07, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h09, "R1 count by two");
        op(2'd0, 1, 0, 8'h40, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h40, "R1 write beats count");

        // R5 overflow
        op(2'd0, 1, 0, 8'hFE, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h30, "R5 overflow flag");

        // R6 write zero without read keeps flag; R7 write one sets nothing
        op(2'd3, 1, 0, 8'h10, 0, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h30, "R6 unarmed clear ignored");
        op(2'd3, 1, 0, 8'hF0, 0, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h30, "R7 write one ignored");
        op(2'd3, 0, 1, 8'h00, 0, 0);
        op(2'd3, 1, 0, 8'h10, 0, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h10, "R6 read then clear");

        // R3 and R8
        op(2'd1, 1, 0, 8'h05, 0, 0);
        op(2'd0, 1, 0, 8'h05, 0, 0);
        op(2'd3, 0, 0, 8'h00, 1, 0);
        op(2'd3, 0, 1, 8'h00, 0, 0); check(last_rd, 8'h50, "R3 compare A flag");
        op(2'd0, 1, 0, 8'h05, 0, 0);
        op(2'd3, 1, 0, 8'h10, 1, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h50, "R8 set beats clear");
        op(2'd3, 0, 1, 8'h00, 0, 0);
        op(2'd3, 1, 0, 8'h10, 0, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h10, "R6 clear after collision");

        // R4 and R9 output actions
        op(2'd2, 1, 0, 8'h20, 0, 0);
        op(2'd3, 1, 0, 8'h18, 0, 0);
        op(2'd0, 1, 0, 8'h20, 0, 0);
        op(2'd3, 0, 0, 8'h00, 1, 0);
        op(2'd3, 0, 0, 8'h00, 0, 0); check(last_rd, 8'h98, "R4 compare B flag");
        check({7'd0, last_wave}, 8'h01, "R9 drive high");
        op(2'd3, 1, 0, 8'h1C, 0, 0);
        op(2'd0, 1, 0, 8'h20, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check({7'd0, last_wave}, 8'h00, "R9 toggle to low");
        op(2'd0, 1, 0, 8'h20, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check({7'd0, last_wave}, 8'h01, "R9 toggle to high");
        op(2'd3, 1, 0, 8'h10, 0, 0);
        op(2'd0, 1, 0, 8'h20, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check({7'd0, last_wave}, 8'h01, "R9 hold on match");
        op(2'd3, 1, 0, 8'h14, 0, 0);
        op(2'd0, 1, 0, 8'h20, 0, 0);
        op(2'd0, 0, 0, 8'h00, 1, 0);
        op(2'd0, 0, 0, 8'h00, 0, 0); check({7'd0, last_wave}, 8'h00, "R9 drive low");

        // R10 capture gating
        op(2'd3, 1, 0, 8'h00, 0, 0);
        op(2'd0, 0, 0, 8'h00, 0, 1); check({7'd0, last_irq}, 8'h00, "R10 gated off");
        op(2'd3, 1, 0, 8'h10, 0, 0);
        op(2'd0, 0, 0, 8'h00, 0, 1); check({7'd0, last_irq}, 8'h01, "R10 passes flag");

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] a;
            logic w, r;
            logic [7:0] d;
            int sel;
            sel = $urandom_range(0, 9);
            a = 2'($urandom_range(0, 3));
            w = 1'b0; r = 1'b0;
            d = 8'($urandom);
            if (sel < 3) begin a = 2'd3; r = 1'b1; end
            else if (sel < 5) w = 1'b1;
            else if (sel == 5) begin a = 2'd0; w = 1'b1; d = (k[0]) ? m_ca : m_cb; end
            op(a, w, r, d, $urandom_range(0, 9) < 7, 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule